// File: doc/BRIEF.md
# Memory Size Autoprobe Engine

This engine acts as a bus master. It finds out whether a memory region holds working RAM and, if it does, how many bytes the region spans. One `start` pulse launches a probe. The engine then runs a short fixed sequence of word transactions on a simple request/acknowledge port. When the sequence ends it raises `done` for one cycle and posts a presence flag and a byte size.

The probe only ever writes to the two lowest words of the region. It reads and saves both words first, and writes them back before it reports, so the contents above those two words are never disturbed.

Presence is judged by writing a pattern to the lowest word and then writing a complementary pattern to the next word. The second write drives different data onto the bus, so a floating bus cannot echo the first pattern back. The engine then reads the lowest word back, and does the whole check a second time with the two patterns swapped.

Sizing uses address wrap-around. At each doubling offset the engine does four things:
- it reads the word at that offset;
- it writes the inverse of that word to offset 0;
- it reads offset 0;
- it reads the offset again.

If the two reads agree, the offset aliases onto word 0, and the offset is the size. The region must be a power of two in size. The largest span probed is the parameter `MAX_SPAN` (bytes, a power of two, at least 8). Retrying with a different bus width is left to the logic around the engine.

Top module: `mem_autosize`

## Requirements
- R1: Before any write, the engine reads byte offsets 0 and 4 and keeps both words. Its last two writes of every probe put those saved words back at offsets 0 and 4, whatever the result.
- R2: First presence check: write 0x5555AAAA to offset 0, then write 0xAAAA5555 to offset 4, then read offset 0. A value other than 0x5555AAAA reports size 0 and present 0.
- R3: If the first check passes, a second check runs with the patterns swapped: 0xAAAA5555 goes to offset 0 and 0x5555AAAA to offset 4, then offset 0 is read. A mismatch reports size 0 and present 0.
- R4: The sizing step runs at offsets 4, 8, 16 and so on, doubling each time. Each step reads the offset, writes the inverse of that word to offset 0, reads offset 0, then reads the offset again. Equal reads stop the loop, and the reported size is that offset. For a memory of power-of-two size S with 8 <= S <= MAX_SPAN, this yields S; when S equals MAX_SPAN, R5 applies instead.
- R5: If the doubled offset reaches MAX_SPAN without a wrap, the reported size is MAX_SPAN and present is 1.
- R6: Writes only ever target byte offsets 0 and 4.
- R7: `mreq` is high for one cycle per transaction, and only one transaction is outstanding at a time. Every transaction, whether read or write, is closed by one `mrvalid` pulse that comes at least one cycle after `mreq`. `mwe` = 1 marks a write.
- R8: `done` is a one-cycle pulse. `size` and `present` change only in the cycle `done` is high, and hold their values at other times, including while a later probe runs. After reset, `done`, `present`, `size` and `mreq` are all 0.
- R9: A `start` that arrives while a probe is running is ignored. It neither restarts the probe nor produces an extra `done`.
- R10: `present` is 1 exactly when `size` is nonzero. A nonzero `size` is a power of two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launches a probe when the engine is idle |
| done | output | 1 | One-cycle pulse when a probe ends |
| present | output | 1 | Working RAM found |
| size | output | $clog2(MAX_SPAN)+1 | Detected size in bytes |
| mreq | output | 1 | Transaction request pulse |
| mwe | output | 1 | 1 = write, 0 = read |
| maddr | output | $clog2(MAX_SPAN) | Byte address of the transaction |
| mwdata | output | 32 | Write data |
| mrdata | input | 32 | Read data, valid with mrvalid |
| mrvalid | input | 1 | Completion of the outstanding transaction |

## Verification
The bench attaches a behavioural memory. It can alias addresses modulo a chosen size, hold one data bit stuck, or be absent altogether, in which case the bus keeps the last value driven on it.

Absent memory checks the bus-disturbing write: without it, the held bus would echo the pattern back and an empty region would report a size. A bit stuck at 0 in bit 0 passes the first pattern but fails the swapped one, which catches an engine that skips the second check. The smallest wrap (8 bytes) and a region equal to the full span check the loop's start offset and its exit at the limit; an off-by-one doubling would report twice or half the size. Each run also checks that the two saved words come back, that no write lands outside offsets 0 and 4, and that a `start` in mid-probe yields no second `done`.

// File: rtl/mem_autosize.sv
module mem_autosize #(
  parameter int MAX_SPAN = 1 << 20,
  localparam int AW = $clog2(MAX_SPAN),
  localparam int SW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          done,
  output logic          present,
  output logic [SW-1:0] size,
  output logic          mreq,
  output logic          mwe,
  output logic [AW-1:0] maddr,
  output logic [31:0]   mwdata,
  input  logic [31:0]   mrdata,
  input  logic          mrvalid
);
  typedef enum logic [3:0] {
    IDLE, SV0, SV1, A0, A1, AR, B0, B1, BR, TR, TW, TR0, TR1, RS0, RS1
  } st_t;

  localparam logic [31:0]   PA   = 32'h5555_AAAA;
  localparam logic [31:0]   PB   = 32'hAAAA_5555;
  localparam logic [SW-1:0] MAXV = SW'(MAX_SPAN);
  localparam logic [SW-1:0] FOUR = SW'(4);

  st_t st;
  logic pend;
  logic [31:0] save0, save1, tval, v0;
  logic [SW-1:0] ofs, res;

  wire ack = pend && mrvalid;
  wire [SW-1:0] nofs = ofs << 1;

  always_comb begin
    mwe    = 1'b0;
    maddr  = '0;
    mwdata = '0;
    case (st)
      SV1:     maddr = AW'(4);
      A0:      begin mwe = 1'b1; mwdata = PA; end
      A1:      begin mwe = 1'b1; maddr = AW'(4); mwdata = PB; end
      B0:      begin mwe = 1'b1; mwdata = PB; end
      B1:      begin mwe = 1'b1; maddr = AW'(4); mwdata = PA; end
      TR, TR1: maddr = ofs[AW-1:0];
      TW:      begin mwe = 1'b1; mwdata = ~tval; end
      RS0:     begin mwe = 1'b1; mwdata = save0; end
      RS1:     begin mwe = 1'b1; maddr = AW'(4); mwdata = save1; end
      default: ;
    endcase
  end

  assign mreq = (st != IDLE) && !pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      pend    <= 1'b0;
      save0   <= '0;
      save1   <= '0;
      tval    <= '0;
      v0      <= '0;
      ofs     <= FOUR;
      res     <= '0;
      size    <= '0;
      present <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (mreq) pend <= 1'b1;
      if (st == IDLE && start) st <= SV0;
      if (ack) begin
        pend <= 1'b0;
        case (st)
          SV0: begin save0 <= mrdata; st <= SV1; end
          SV1: begin save1 <= mrdata; st <= A0; end
          A0:  st <= A1;
          A1:  st <= AR;
          AR:  if (mrdata == PA) st <= B0;
               else begin res <= '0; st <= RS0; end
          B0:  st <= B1;
          B1:  st <= BR;
          BR:  if (mrdata != PB) begin res <= '0; st <= RS0; end
               else if (FOUR >= MAXV) begin res <= MAXV; st <= RS0; end
               else begin ofs <= FOUR; st <= TR; end
          TR:  begin tval <= mrdata; st <= TW; end
          TW:  st <= TR0;
          TR0: begin v0 <= mrdata; st <= TR1; end
          TR1: if (mrdata == v0) begin res <= ofs; st <= RS0; end
               else if (nofs >= MAXV) begin res <= MAXV; st <= RS0; end
               else begin ofs <= nofs; st <= TR; end
          RS0: st <= RS1;
          RS1: begin
            size    <= res;
            present <= (res != '0);
            done    <= 1'b1;
            st      <= IDLE;
          end
          default: st <= IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mem_autosize_chk.sv
module mem_autosize_chk #(
  parameter int SW = 21,
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          present,
  input logic [SW-1:0] size,
  input logic          mreq,
  input logic          mwe,
  input logic [AW-1:0] maddr,
  input logic          mrvalid
);
  logic open;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open <= 1'b0;
    else if (mreq) open <= 1'b1;
    else if (mrvalid) open <= 1'b0;
  end

  p_single_txn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mreq |-> !open);
  p_req_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mreq |=> !mreq);
  p_write_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq && mwe) |-> (maddr == AW'(0) || maddr == AW'(4)));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_size_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(size) && $stable(present));
  p_present_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (present == (size != '0)));
  p_size_pow2_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && present) |-> ($countones(size) == 1));
endmodule

bind mem_autosize mem_autosize_chk #(.SW(SW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .present(present), .size(size),
  .mreq(mreq), .mwe(mwe), .maddr(maddr), .mrvalid(mrvalid)
);

// File: tb/mem_autosize_bench.sv
module mem_autosize_bench;
  localparam int SPAN = 1024;
  localparam int AW = $clog2(SPAN);
  localparam int SW = AW + 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic done, present, mreq, mwe, mrvalid;
  logic [SW-1:0] size;
  logic [AW-1:0] maddr;
  logic [31:0] mwdata, mrdata;

  always #4 clk = ~clk;

  mem_autosize #(.MAX_SPAN(SPAN)) u_mem_autosize (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .present(present),
    .size(size), .mreq(mreq), .mwe(mwe), .maddr(maddr), .mwdata(mwdata),
    .mrdata(mrdata), .mrvalid(mrvalid)
  );

  int msz = 0, lat = 1;
  logic [31:0] stk0 = '0, stk1 = '0;
  logic [31:0] mem [SPAN/4];
  logic [31:0] bus_last = '0, rd_hold = '0;
  int cnt = 0;
  int ndone = 0, bad_wr = 0, ovl = 0;
  logic open = 1'b0, mv = 1'b0;
  int tests = 0, fails = 0;

  assign mrvalid = mv;
  assign mrdata = rd_hold;

  function automatic int idx(input logic [AW-1:0] a);
    return (msz == 0) ? 0 : ((int'(a) % msz) / 4);
  endfunction

  always @(posedge clk) begin
    mv <= 1'b0;
    if (cnt != 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) mv <= 1'b1;
    end
    if (mreq) begin
      cnt <= lat;
      if (mwe) begin
        bus_last <= mwdata;
        if (msz != 0) mem[idx(maddr)] <= (mwdata & ~stk0) | stk1;
      end else if (msz != 0) begin
        rd_hold  <= (mem[idx(maddr)] & ~stk0) | stk1;
        bus_last <= (mem[idx(maddr)] & ~stk0) | stk1;
      end else begin
        rd_hold <= bus_last;
      end
    end
  end

  always @(posedge clk) begin
    if (done) ndone <= ndone + 1;
    if (mreq && mwe && maddr != 0 && maddr != 4) bad_wr <= bad_wr + 1;
    if (mreq && open) ovl <= ovl + 1;
    if (mreq) open <= 1'b1;
    else if (mrvalid) open <= 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] initw(input int i);
    return 32'hC0DE_0000 + 32'(i * 16);
  endfunction

  task automatic fill();
    for (int i = 0; i < SPAN / 4; i++) mem[i] = initw(i);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(output bit got);
    got = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (done) begin got = 1'b1; return; end
    end
  endtask

  task automatic probe(input int sz, input int lt, input int exp_sz, input string tag);
    bit got;
    int d0, w0, o0;
    msz = sz; lat = lt; fill();
    d0 = ndone; w0 = bad_wr; o0 = ovl;
    pulse_start();
    wait_done(got);
    chk(got, tag, got, 1);
    chk(size == SW'(exp_sz), tag, size, exp_sz);
    chk(present == (exp_sz != 0), "R10", present, exp_sz != 0);
    @(negedge clk);
    chk(!done, "R8", done, 0);
    chk(ndone == d0 + 1, "R8", ndone - d0, 1);
    chk(bad_wr == w0, "R6", bad_wr - w0, 0);
    chk(ovl == o0, "R7", ovl - o0, 0);
    if (sz != 0) begin
      chk(mem[0] == ((initw(0) & ~stk0) | stk1), "R1", mem[0], initw(0));
      chk(mem[1] == ((initw(1) & ~stk0) | stk1), "R1", mem[1], initw(1));
    end
  endtask

  task automatic t_reset();
    chk(!done && !present && size == 0 && !mreq, "R8", {done, present, mreq}, 0);
  endtask

  task automatic t_full_span();
    probe(SPAN, 1, SPAN, "R5");
  endtask

  task automatic t_wrap_sizes();
    probe(8, 1, 8, "R4");
    probe(64, 3, 64, "R4");
    probe(256, 2, 256, "R4");
  endtask

  task automatic t_absent();
    probe(0, 2, 0, "R2");
  endtask

  task automatic t_stuck();
    stk0 = 32'h1;
    probe(128, 1, 0, "R3");
    stk0 = '0;
  endtask

  task automatic t_restart_ignored();
    bit got;
    int d0;
    msz = 32; lat = 2; fill();
    d0 = ndone;
    pulse_start();
    repeat (10) @(negedge clk);
    pulse_start();
    wait_done(got);
    chk(got && size == SW'(32), "R9", size, 32);
    repeat (60) @(negedge clk);
    chk(ndone == d0 + 1, "R9", ndone - d0, 1);
  endtask

  task automatic t_hold();
    logic [SW-1:0] prev;
    bit got;
    prev = size;
    repeat (20) @(negedge clk);
    chk(size == prev && present, "R8", size, prev);
    msz = 16; fill();
    pulse_start();
    repeat (4) @(negedge clk);
    chk(size == prev, "R8", size, prev);
    wait_done(got);
    chk(got && size == SW'(16), "R4", size, 16);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_full_span();
    t_wrap_sizes();
    t_absent();
    t_stuck();
    t_restart_ignored();
    t_hold();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
  end
endmodule